// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two two's-complement operands of `N` bits, one recoded multiplier bit per clock, and returns a signed product of `2N` bits split into a high word and a low word. A single-cycle start strobe, taken while the block is idle, captures the multiplicand in a holding register. The same strobe clears the upper half of a combined product register, puts the multiplier in its lower half and clears one extra bit appended on the right.

On each working cycle the two lowest bits of that register are inspected: the low product bit and the extra bit. A pair of 1,0 subtracts the multiplicand from the upper half. A pair of 0,1 adds it. Pairs 0,0 and 1,1 leave the upper half unchanged. The whole register, including the extra bit, then shifts right by one with the sign copied in. After `N` such steps the upper half holds the high word and the lower half holds the low word. The arithmetic on the upper half uses one guard bit, so subtracting the most negative multiplicand cannot lose the sign. The caller waits for the one-cycle completion flag and reads the result. The result stays in place until the next accepted start.

Top module: `booth_mult_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no start yet, `busy_o`, `done_o`, `prod_hi_o` and `prod_lo_o` are all zero.
- R2: A start strobe sampled while idle is accepted, and `busy_o` reads 1 in the next cycle.
- R3: `done_o` rises exactly `N` clock edges after the edge that accepted the start. It is high for exactly one cycle, and `busy_o` is 0 while `done_o` is high.
- R4: When `done_o` is high, `{prod_hi_o, prod_lo_o}` equals the signed product of `mcand_i` and `mplier_i` as sampled at start, as a two's-complement value of `2N` bits. The high word carries product bits 2N-1..N and the low word bits N-1..0.
- R5: The product is exact when either operand, or both, is the most negative value -2^(N-1).
- R6: A start strobe that arrives while `busy_o` is 1 has no effect. The operation in progress finishes on its original schedule, with the product of its original operands.
- R7: After `done_o`, `prod_hi_o` and `prod_lo_o` hold their value until the next accepted start.
- R8: The small cases 2 x 7 and 2 x (-3) give 14 and -6. For 4-bit operands, -6 would read high 1111, low 1010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| mcand_i | input | N | Signed multiplicand, sampled at start |
| mplier_i | input | N | Signed multiplier, sampled at start |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle flag: product valid |
| prod_hi_o | output | N | Upper word of the signed product |
| prod_lo_o | output | N | Lower word of the signed product |

## Verification
The bench builds the block with `N = 8`. At that width -128 can be driven as either operand or both, and each random operand draw lands on all-ones, zero or the extreme values often enough that runs of ones cover every recoding pair. The short width also keeps each multiply to ten cycles. This leaves room for several hundred random products, and for some of them a start strobe is injected mid-operation to show that it is ignored. The values 2 x 7 and 2 x (-3) are run directly; at this width they appear as sign-extended 16-bit results.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Action selected by one radix-2 recoding step.
  typedef enum logic [1:0] {
    BOOTH_NONE = 2'd0,
    BOOTH_ADD  = 2'd1,
    BOOTH_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_i,   // low bit of the product register
  input  logic      prev_i,  // appended bit to its right
  output booth_op_e op_o
);
  always_comb begin
    unique case ({cur_i, prev_i})
      2'b10:   op_o = BOOTH_SUB;   // run of ones starts
      2'b01:   op_o = BOOTH_ADD;   // run of ones has ended
      default: op_o = BOOTH_NONE;  // inside a run of ones or zeros
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 33
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  booth_op_e    op_i,
  output logic [W-1:0] sum_o
);
  always_comb begin
    unique case (op_i)
      BOOTH_ADD: sum_o = acc_i + opnd_i;
      BOOTH_SUB: sum_o = acc_i - opnd_i;
      default:   sum_o = acc_i;
    endcase
  end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last   = busy_q && (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = last;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R3
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> busy_q); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST)); // R3
endmodule

// File: rtl/booth_mult_seq.sv
module booth_mult_seq
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] prod_hi_o,
  output logic [N-1:0] prod_lo_o
);
  localparam int HW = N + 1;  // upper half plus guard bit

  logic          load, step;
  logic [N-1:0]  mcand_q;
  logic [HW-1:0] hi_q, hi_d;
  logic [N-1:0]  lo_q, lo_d;
  logic          xb_q, xb_d;
  logic [HW-1:0] sum;
  booth_op_e     op;

  booth_seq_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  booth_recode u_recode (
    .cur_i  (lo_q[0]),
    .prev_i (xb_q),
    .op_o   (op)
  );

  booth_addsub #(.W(HW)) u_addsub (
    .acc_i  (hi_q),
    .opnd_i ({mcand_q[N-1], mcand_q}),
    .op_i   (op),
    .sum_o  (sum)
  );

  // Next state: load, or add/sub then arithmetic right shift by one.
  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    xb_d = xb_q;
    if (load) begin
      hi_d = '0;
      lo_d = mplier_i;
      xb_d = 1'b0;
    end else if (step) begin
      hi_d = {sum[HW-1], sum[HW-1:1]};
      lo_d = {sum[0], lo_q[N-1:1]};
      xb_d = lo_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
    end else if (load) begin
      mcand_q <= mcand_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      xb_q <= 1'b0;
    end else if (load || step) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      xb_q <= xb_d;
    end
  end

  assign prod_hi_o = hi_q[N-1:0];
  assign prod_lo_o = lo_q;

  AST_GUARD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (hi_q[HW-1] == hi_q[N-1])); // R5
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(mcand_q)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(prod_hi_o) && $stable(prod_lo_o))); // R7
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (hi_q == '0 && xb_q == 1'b0)); // R2
endmodule

// File: tb/booth_mult_seq_test.sv
`timescale 1ns/1ps
module booth_mult_seq_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [N-1:0] mcand_i = '0;
  logic [N-1:0] mplier_i = '0;
  logic         busy_o, done_o;
  logic [N-1:0] prod_hi_o, prod_lo_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  booth_mult_seq #(.N(N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .prod_hi_o (prod_hi_o),
    .prod_lo_o (prod_lo_o)
  );

  function automatic logic [2*N-1:0] ref_prod(input logic [N-1:0] a, input logic [N-1:0] b);
    logic signed [2*N-1:0] sa, sb;
    sa = {{N{a[N-1]}}, a};
    sb = {{N{b[N-1]}}, b};
    return sa * sb;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // One multiply; poke injects a start with other operands while busy.
  task automatic do_mul(input logic [N-1:0] a, input logic [N-1:0] b, input string req, input bit poke);
    logic [2*N-1:0] exp;
    int k;
    exp = ref_prod(a, b);
    @(negedge clk);
    start_i = 1'b1; mcand_i = a; mplier_i = b;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2", 64'(busy_o), 64'd1);
    if (poke) begin
      start_i = 1'b1; mcand_i = ~a; mplier_i = b ^ 8'h5A;
    end
    k = 0;
    while (!done_o && k < 4*N) begin
      @(negedge clk);
      start_i = 1'b0;
      k++;
    end
    check(k == N, poke ? "R6 timing" : "R3 latency", 64'(k), 64'(N));
    check(busy_o == 1'b0, "R3 busy", 64'(busy_o), 64'd0);
    check({prod_hi_o, prod_lo_o} == exp, req, 64'({prod_hi_o, prod_lo_o}), 64'(exp));
    @(negedge clk);
    check(done_o == 1'b0, "R3 pulse", 64'(done_o), 64'd0);
    repeat (2) @(negedge clk);
    check({prod_hi_o, prod_lo_o} == exp, "R7 hold", 64'({prod_hi_o, prod_lo_o}), 64'(exp));
  endtask

  function automatic logic [N-1:0] pick_operand();
    int unsigned r;
    r = $urandom_range(0, 9);
    case (r)
      0: return 8'h80;
      1: return 8'h7F;
      2: return 8'hFF;
      3: return 8'h00;
      default: return N'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R3 watchdog", 64'd0, 64'd1);
    summary();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1: during reset
    check({busy_o, done_o, prod_hi_o, prod_lo_o} == '0, "R1 in reset",
          64'({busy_o, done_o, prod_hi_o, prod_lo_o}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({busy_o, done_o, prod_hi_o, prod_lo_o} == '0, "R1 after reset",
          64'({busy_o, done_o, prod_hi_o, prod_lo_o}), 64'd0);

    do_mul(8'd2, 8'd7, "R8 2x7", 1'b0);
    do_mul(8'd2, 8'hFD, "R8 2x-3", 1'b0);
    do_mul(8'h80, 8'h80, "R5 min x min", 1'b0);
    do_mul(8'h80, 8'h01, "R5 min x 1", 1'b0);
    do_mul(8'h80, 8'hFF, "R5 min x -1", 1'b0);
    do_mul(8'h7F, 8'h80, "R5 max x min", 1'b0);
    do_mul(8'hFF, 8'hFF, "R4 -1 x -1", 1'b0);
    do_mul(8'h00, 8'h55, "R4 zero", 1'b0);
    do_mul(8'h33, 8'h80, "R6 poke", 1'b1);

    for (int i = 0; i < 400; i++) begin
      do_mul(pick_operand(), pick_operand(), "R4 random", (i % 7) == 3);
    end
    summary();
  end
endmodule